// File: doc/BRIEF.md
# Serial Converter Interface Sequencer

This block is the device-side digital control of a serial successive-approximation converter with an input multiplexer. A host drives chip select (active low), a serial clock and a data-in line. While chip select is low, the block shifts in a five-bit command on rising clock edges. It then opens an acquisition window and runs a fixed-length conversion. Finally it returns an eleven-bit signed code, least significant bit first, on falling clock edges. The analog comparator is outside the block: one decision bit per conversion step arrives on `cmp_i`.

The host may raise chip select during a conversion. The conversion still completes, and the code waits until chip select falls again. A command whose leading bit is clear puts the converter into software power-down. A hardware power-down pin stops everything, and a recovery count must then run with chip select high before the next command is accepted. The first code after reset is flagged invalid.

Top module: `adc_serial_seq`

## Requirements
- R1: While chip select is low, rising clock edges shift `din_i` into a 5-bit command, first bit first, in this order: power-up, single/differential, odd/sign, select1, select0. When power-up is 1, `mux_cfg_o` takes the last four bits as {single/differential, odd/sign, select1, select0}.
- R2: A command with power-up = 0 raises `pwr_dn_o`, keeps `mux_en_o` low, starts no conversion and leaves `mux_cfg_o` unchanged. A rising edge with chip select high clears it.
- R3: After the fifth command bit, `mux_en_o` is high and `busy_o` is low for ACQ_CYCLES (default 4) clocks before the conversion starts.
- R4: A conversion lasts CONV_CYCLES (default 12) clocks. While chip select is low, `busy_o` is high for exactly those clocks and low at all other times.
- R5: The first RES_BITS (11) conversion clocks sample `cmp_i`. The first decision becomes the sign (code bit 10), and the following decisions fill magnitude bits 9 down to 0.
- R6: Readout drives code bits 0 through 9 and then the sign on `dout_o`, one per falling edge, starting at the first falling edge of readout. `dout_o` is 0 once all bits are out.
- R7: While chip select is high, `busy_oe_o` and `dout_oe_o` are low. `dout_oe_o` is high only during readout with chip select low.
- R8: If chip select goes high during a conversion, the conversion completes and the code is held. Readout begins on the first falling edge after a rising edge that sees chip select low.
- R9: After readout, no new command is taken until a rising edge sees chip select high. Holding chip select low starts nothing.
- R10: While `pd_i` is high, `pwr_dn_o` is high and `ready_o` is low. After `pd_i` falls, `ready_o` rises once RECOV_CYCLES (default 8) consecutive rising edges have seen chip select high. Chip select low before that restarts the count, and no command is taken until ready.
- R11: `res_valid_o` is low for the code from the first conversion after reset and high for every later code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Serial clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Chip select, active low |
| din_i | input | 1 | Serial command input |
| pd_i | input | 1 | Hardware power-down, active high |
| cmp_i | input | 1 | Comparator decision for the current step |
| dout_o | output | 1 | Serial code output |
| dout_oe_o | output | 1 | Drive enable for `dout_o` |
| busy_o | output | 1 | Conversion in progress |
| busy_oe_o | output | 1 | Drive enable for `busy_o` |
| mux_cfg_o | output | 4 | Loaded channel/mode field |
| mux_en_o | output | 1 | Inputs connected (acquire or convert) |
| pwr_dn_o | output | 1 | Software or hardware power-down active |
| ready_o | output | 1 | Power-up recovery complete |
| res_valid_o | output | 1 | Held code is valid |

## Verification
Conversions are run with several command words and codes. The codes use alternating bits, all ones, and a lone set LSB, so the serial order can be told apart from a reversed or shifted order. The same conversion is run once with chip select held low and once with it parked high during conversion, to separate readout hold-off from the reset path. A command with a cleared power-up bit shows that the configuration field is ignored. A hardware power-down with a chip-select glitch during recovery shows the count restarting and that commands sent during recovery are dropped.

// File: rtl/adc_seq_pkg.sv
`timescale 1ns/1ps
package adc_seq_pkg;
  localparam int unsigned ADDR_BITS = 5;

  typedef enum logic [3:0] {
    ST_WAIT, ST_IDLE, ST_ADDR, ST_ACQ, ST_CONV,
    ST_HOLD, ST_OUT, ST_SPD, ST_HWPD
  } seq_state_e;
endpackage

// File: rtl/adc_pwr_recovery.sv
`timescale 1ns/1ps
module adc_pwr_recovery #(
  parameter int unsigned RECOV_CYCLES = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pd_i,
  input  logic cs_ni,
  output logic ready_o
);
  localparam int unsigned RW = $clog2(RECOV_CYCLES + 1);
  localparam logic [RW-1:0] RLAST = RW'(RECOV_CYCLES);

  logic [RW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= RLAST;
    else if (pd_i)            cnt_q <= '0;
    else if (cnt_q == RLAST)  cnt_q <= cnt_q;
    else if (cs_ni)           cnt_q <= cnt_q + 1'b1;
    else                      cnt_q <= '0;   // cs low restarts recovery
  end

  assign ready_o = (cnt_q == RLAST);

  p_pd_clears_ready_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pd_i |=> !ready_o);
endmodule

// File: rtl/adc_sar_capture.sv
`timescale 1ns/1ps
module adc_sar_capture #(
  parameter int unsigned RES_BITS = 11
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                bit_en_i,
  input  logic                cmp_i,
  output logic [RES_BITS-1:0] result_o
);
  // decisions arrive sign first, then MSB to LSB
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       result_o <= '0;
    else if (bit_en_i) result_o <= {result_o[RES_BITS-2:0], cmp_i};
  end

  p_result_held_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bit_en_i |=> $stable(result_o));
endmodule

// File: rtl/adc_dout_shifter.sv
`timescale 1ns/1ps
module adc_dout_shifter #(
  parameter int unsigned RES_BITS = 11
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                active_i,
  input  logic [RES_BITS-1:0] result_i,
  output logic                dout_o
);
  localparam int unsigned CW = $clog2(RES_BITS + 1);
  localparam logic [CW-1:0] CLAST = CW'(RES_BITS);

  logic [CW-1:0] cnt_q;

  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      dout_o <= 1'b0;
    end else if (!active_i) begin
      cnt_q  <= '0;
      dout_o <= 1'b0;
    end else if (cnt_q != CLAST) begin
      dout_o <= result_i[cnt_q];
      cnt_q  <= cnt_q + 1'b1;
    end else begin
      dout_o <= 1'b0;
    end
  end

  p_dout_quiet_r6: assert property (@(negedge clk_i) disable iff (!rst_ni)
    !active_i |=> (dout_o == 1'b0));
endmodule

// File: rtl/adc_seq_ctrl.sv
`timescale 1ns/1ps
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int unsigned RES_BITS    = 11,
  parameter int unsigned ACQ_CYCLES  = 4,
  parameter int unsigned CONV_CYCLES = 12
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 cs_ni,
  input  logic                 din_i,
  input  logic                 pd_i,
  input  logic                 ready_i,
  output seq_state_e           state_o,
  output logic [ADDR_BITS-2:0] mux_cfg_o,
  output logic                 bit_en_o,
  output logic                 res_valid_o
);
  localparam int unsigned AW = $clog2(ACQ_CYCLES + 1);
  localparam int unsigned CW = $clog2(CONV_CYCLES + 1);
  localparam int unsigned NW = $clog2(ADDR_BITS + 1);
  localparam logic [AW-1:0] ACQ_LAST  = AW'(ACQ_CYCLES - 1);
  localparam logic [CW-1:0] CONV_LAST = CW'(CONV_CYCLES - 1);
  localparam logic [CW-1:0] RES_LIM   = CW'(RES_BITS);
  localparam logic [NW-1:0] ADDR_LAST = NW'(ADDR_BITS - 1);

  seq_state_e             state_q;
  logic [ADDR_BITS-2:0]   addr_q;
  logic [NW-1:0]          addr_cnt_q;
  logic [AW-1:0]          acq_cnt_q;
  logic [CW-1:0]          conv_cnt_q;
  logic [ADDR_BITS-2:0]   cfg_q;
  logic                   first_q;
  logic                   valid_q;
  logic [ADDR_BITS-1:0]   word;

  assign word = {addr_q, din_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_WAIT;
      addr_q     <= '0;
      addr_cnt_q <= '0;
      acq_cnt_q  <= '0;
      conv_cnt_q <= '0;
      cfg_q      <= '0;
      first_q    <= 1'b1;
      valid_q    <= 1'b0;
    end else if (pd_i) begin
      state_q <= ST_HWPD;
    end else begin
      unique case (state_q)
        ST_HWPD: state_q <= ST_WAIT;
        ST_WAIT: if (cs_ni && ready_i) state_q <= ST_IDLE;
        ST_IDLE: if (!cs_ni) begin
          addr_q     <= {addr_q[ADDR_BITS-3:0], din_i};
          addr_cnt_q <= NW'(1);
          state_q    <= ST_ADDR;
        end
        ST_ADDR: begin
          if (cs_ni) begin
            state_q <= ST_IDLE;
          end else begin
            addr_q     <= {addr_q[ADDR_BITS-3:0], din_i};
            addr_cnt_q <= addr_cnt_q + 1'b1;
            if (addr_cnt_q == ADDR_LAST) begin
              if (word[ADDR_BITS-1]) begin
                cfg_q     <= word[ADDR_BITS-2:0];
                acq_cnt_q <= '0;
                state_q   <= ST_ACQ;
              end else begin
                state_q <= ST_SPD;
              end
            end
          end
        end
        ST_ACQ: begin
          acq_cnt_q <= acq_cnt_q + 1'b1;
          if (acq_cnt_q == ACQ_LAST) begin
            conv_cnt_q <= '0;
            state_q    <= ST_CONV;
          end
        end
        ST_CONV: begin
          conv_cnt_q <= conv_cnt_q + 1'b1;
          if (conv_cnt_q == CONV_LAST) begin
            valid_q <= !first_q;
            first_q <= 1'b0;
            state_q <= cs_ni ? ST_HOLD : ST_OUT;
          end
        end
        ST_HOLD: if (!cs_ni) state_q <= ST_OUT;
        ST_OUT, ST_SPD: if (cs_ni) state_q <= ST_IDLE;
        default: state_q <= ST_WAIT;
      endcase
    end
  end

  assign state_o     = state_q;
  assign mux_cfg_o   = cfg_q;
  assign res_valid_o = valid_q;
  assign bit_en_o    = (state_q == ST_CONV) && (conv_cnt_q < RES_LIM) && !pd_i;

  p_spd_no_conv_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SPD) |=> (state_q != ST_ACQ && state_q != ST_CONV));
  p_conv_end_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_CONV && conv_cnt_q == CONV_LAST && !pd_i)
      |=> (state_q == ST_OUT || state_q == ST_HOLD));
  p_hold_keeps_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_HOLD && cs_ni && !pd_i) |=> (state_q == ST_HOLD));
  p_out_needs_cs_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_OUT && !cs_ni && !pd_i) |=> (state_q == ST_OUT));
  p_idle_needs_ready_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WAIT && !ready_i) |=> (state_q != ST_IDLE));
endmodule

// File: rtl/adc_serial_seq.sv
`timescale 1ns/1ps
module adc_serial_seq
  import adc_seq_pkg::*;
#(
  parameter int unsigned RES_BITS     = 11,
  parameter int unsigned ACQ_CYCLES   = 4,
  parameter int unsigned CONV_CYCLES  = 12,
  parameter int unsigned RECOV_CYCLES = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 cs_ni,
  input  logic                 din_i,
  input  logic                 pd_i,
  input  logic                 cmp_i,
  output logic                 dout_o,
  output logic                 dout_oe_o,
  output logic                 busy_o,
  output logic                 busy_oe_o,
  output logic [ADDR_BITS-2:0] mux_cfg_o,
  output logic                 mux_en_o,
  output logic                 pwr_dn_o,
  output logic                 ready_o,
  output logic                 res_valid_o
);
  seq_state_e          state;
  logic                bit_en;
  logic                ready;
  logic [RES_BITS-1:0] result;

  adc_pwr_recovery #(.RECOV_CYCLES(RECOV_CYCLES)) u_recov (
    .clk_i, .rst_ni, .pd_i, .cs_ni, .ready_o(ready)
  );

  adc_seq_ctrl #(
    .RES_BITS(RES_BITS), .ACQ_CYCLES(ACQ_CYCLES), .CONV_CYCLES(CONV_CYCLES)
  ) u_ctrl (
    .clk_i, .rst_ni, .cs_ni, .din_i, .pd_i, .ready_i(ready),
    .state_o(state), .mux_cfg_o, .bit_en_o(bit_en), .res_valid_o
  );

  adc_sar_capture #(.RES_BITS(RES_BITS)) u_sar (
    .clk_i, .rst_ni, .bit_en_i(bit_en), .cmp_i, .result_o(result)
  );

  adc_dout_shifter #(.RES_BITS(RES_BITS)) u_dout (
    .clk_i, .rst_ni, .active_i(state == ST_OUT), .result_i(result), .dout_o
  );

  assign ready_o   = ready;
  assign dout_oe_o = !cs_ni && (state == ST_OUT);
  assign busy_oe_o = !cs_ni;
  assign busy_o    = !cs_ni && (state == ST_CONV);
  assign mux_en_o  = (state == ST_ACQ) || (state == ST_CONV);
  assign pwr_dn_o  = (state == ST_SPD) || (state == ST_HWPD);
endmodule

// File: tb/tb_adc_serial_seq.sv
`timescale 1ns/1ps
module tb_adc_serial_seq;
  localparam int CLK_PERIOD = 20;
  localparam int RECOV      = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0, cs_n = 1'b1, din = 1'b0, pd = 1'b0, cmp = 1'b0;
  logic dout, dout_oe, busy, busy_oe, mux_en, pwr_dn, ready, res_valid;
  logic [3:0] mux_cfg;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_serial_seq #(.RES_BITS(11), .ACQ_CYCLES(4), .CONV_CYCLES(12), .RECOV_CYCLES(RECOV)) dut (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .din_i(din), .pd_i(pd), .cmp_i(cmp),
    .dout_o(dout), .dout_oe_o(dout_oe), .busy_o(busy), .busy_oe_o(busy_oe),
    .mux_cfg_o(mux_cfg), .mux_en_o(mux_en), .pwr_dn_o(pwr_dn), .ready_o(ready),
    .res_valid_o(res_valid)
  );

  task automatic tick;
    @(negedge clk); #2;
  endtask

  task automatic chk(input string tag, input logic [10:0] act, input logic [10:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic send_cmd(input logic [4:0] cmd);
    for (int i = 0; i < 5; i++) begin
      cs_n = 1'b0;
      din  = cmd[4-i];
      tick;
    end
  endtask

  // one full conversion; hold=1 parks cs high during conversion
  task automatic run_conv(input logic [4:0] cmd, input logic [10:0] code,
                          input bit hold, input bit exp_valid);
    send_cmd(cmd);
    chk("R1 mux_cfg", mux_cfg, cmd[3:0]);
    chk("R3 mux_en in acquire", mux_en, 1'b1);
    chk("R3 busy low in acquire", busy, 1'b0);
    repeat (3) tick;
    chk("R3 still acquiring", {mux_en, busy}, 2'b10);
    tick;
    chk("R4 busy at conversion start", busy, 1'b1);
    if (hold) cs_n = 1'b1;
    for (int j = 0; j < 11; j++) begin
      cmp = code[10-j];
      tick;
      if (hold) chk("R7 busy_oe low with cs high", busy_oe, 1'b0);
      else      chk("R4 busy during conversion", busy, 1'b1);
    end
    cmp = 1'b0;
    tick;
    chk("R4 conversion ended", {mux_en, busy}, 2'b00);
    if (hold) begin
      repeat (4) begin
        chk("R8 dout_oe low while held", dout_oe, 1'b0);
        tick;
      end
      cs_n = 1'b0;
      tick;
    end
    for (int k = 0; k < 11; k++) begin
      chk(hold ? "R8 held code bit" : "R6 code bit", {dout_oe, dout}, {1'b1, code[k]});
      if (k < 10) tick;
    end
    chk("R5 sign came from first decision", dout, code[10]);
    chk("R11 res_valid", res_valid, exp_valid);
    tick;
    chk("R6 dout after last bit", dout, 1'b0);
    repeat (3) begin
      tick;
      chk("R9 no restart with cs low", {mux_en, busy}, 2'b00);
    end
    cs_n = 1'b1;
    tick;
    chk("R7 enables low with cs high", {dout_oe, busy_oe}, 2'b00);
  endtask

  task automatic spd_test(input logic [4:0] cmd, input logic [3:0] prev_cfg);
    send_cmd(cmd);
    chk("R2 pwr_dn after pu=0", pwr_dn, 1'b1);
    chk("R2 mux_en low", mux_en, 1'b0);
    chk("R2 mux_cfg ignored", mux_cfg, prev_cfg);
    repeat (14) tick;
    chk("R2 no conversion", {busy, mux_en, pwr_dn}, 3'b001);
    cs_n = 1'b1;
    tick;
    chk("R2 cleared by cs high", pwr_dn, 1'b0);
  endtask

  task automatic hwpd_test;
    pd = 1'b1;
    tick;
    chk("R10 pwr_dn with pd", pwr_dn, 1'b1);
    chk("R10 ready low with pd", ready, 1'b0);
    cs_n = 1'b0; din = 1'b1;
    repeat (6) tick;
    chk("R10 no acquire while pd", mux_en, 1'b0);
    pd = 1'b0; cs_n = 1'b1;
    repeat (3) tick;
    chk("R10 not ready early", ready, 1'b0);
    cs_n = 1'b0;
    repeat (5) tick;
    chk("R10 command ignored during recovery", {mux_en, ready}, 2'b00);
    cs_n = 1'b1;
    repeat (RECOV - 1) tick;
    chk("R10 ready one edge short after restart", ready, 1'b0);
    tick;
    chk("R10 ready after full count", ready, 1'b1);
    tick;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) tick;
    rst_n = 1'b1;
    chk("R7 reset enables", {dout_oe, busy_oe}, 2'b00);
    chk("R10 ready after reset", ready, 1'b1);
    chk("R11 reset valid low", res_valid, 1'b0);
    chk("R3 reset mux_en", {mux_en, pwr_dn}, 2'b00);
    tick;
    run_conv(5'b1_1010, 11'b101_0101_0101, 1'b0, 1'b0);
    run_conv(5'b1_0111, 11'b010_0110_1001, 1'b1, 1'b1);
    spd_test(5'b0_1101, 4'b0111);
    hwpd_test;
    run_conv(5'b1_0001, 11'b111_1111_1111, 1'b0, 1'b1);
    run_conv(5'b1_1100, 11'b000_0000_0001, 1'b0, 1'b1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule